// File: doc/BRIEF.md
# Two-Stage Permutation Deflection Arbiter

This block places up to four flits arriving at a mesh router onto the router's four outputs in the same cycle, without any buffering. It is built as two stages of 2x2 steering blocks. Each block picks a winner, sends it toward the half of the outputs it wants, and sends the other flit the other way. A flit that lands on a port other than the one it asked for is marked deflected. Route computation, ejection and injection sit outside this block.

Two priority levels sit above ordinary traffic. A golden flit belongs to the one packet the whole network is currently pushing to completion, and it beats everything. Among golden flits, the lower sequence number wins. Below that, the router marks one valid input per cycle as silver, chosen by a local pseudo-random source. Because the silver flit outranks ordinary flits in every block it passes, at least one flit reaches its requested port whenever any flit is present. Ordinary flits that meet each other are separated by a pseudo-random bit.

The flit streams carry a valid flag only and have no ready. A deflection router must place every arriving flit somewhere in the same cycle, so the arbiter never applies back-pressure. An invalid input is a bubble, and it comes out as an invalid output. The datapath is purely combinational. The only state is the pseudo-random register, which advances on every clock.

Top module: `defl_perm_arbiter`

## Requirements
- R1: Ports are encoded N=0, S=1, E=2, W=3 for both inputs and outputs. The first stage pairs inputs (0,2) and (1,3). Bit 1 of the requested port steers in the first stage, and bit 0 steers in the second stage. Every valid input appears on exactly one output with its data, port request, golden flag and sequence number unchanged. The number of valid outputs equals the number of valid inputs.
- R2: `out_defl[k]` is 1 exactly when output k is valid and its flit requested a port other than k. An invalid output shows valid 0, deflected 0 and all fields 0.
- R3: In any block, a golden flit beats a non-golden one. Between two golden flits, the lower sequence number wins. On equal sequence numbers, the flit from the first-listed side wins. In stage 1 that is the input with the lower index. In stage 2 it is the flit coming from the stage-1 block that holds inputs 0 and 2.
- R4: In any block, a silver flit beats an ordinary flit, and a golden flit beats a silver one.
- R5: Between two ordinary flits, a bit of the pseudo-random register decides: the second-listed flit wins when the bit is 1. Stage-1 blocks use bits 2 and 3, and stage-2 blocks (outputs 0/1 and 2/3) use bits 4 and 5.
- R6: The silver choice starts at the index held in register bits [1:0] and scans upward modulo 4 to the first valid input. `silver_vld` is 1 exactly when any input is valid, and `silver_idx` names the chosen input.
- R7: The pseudo-random register is 16 bits wide and resets asynchronously to 0xACE1. On every clock edge out of reset it shifts left, feeding bit 0 with the XOR of bits 15, 13, 12 and 10.
- R8: When at least one input is valid, at least one valid output is not deflected. The winning golden flit always reaches its requested port.
- R9: A block holding only one valid flit sends that flit to its requested side. A lone flit in the router therefore reaches its requested port undeflected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pseudo-random register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Per-input flit valid |
| in_dest | input | 8 | Requested port per input, 2 bits each |
| in_gold | input | 4 | Per-input golden flag |
| in_seq | input | 16 | Golden sequence number per input, 4 bits each |
| in_data | input | 32 | Payload per input, 8 bits each |
| out_vld | output | 4 | Per-output flit valid |
| out_dest | output | 8 | Requested port of the flit on each output |
| out_gold | output | 4 | Golden flag of the flit on each output |
| out_seq | output | 16 | Sequence number of the flit on each output |
| out_data | output | 32 | Payload of the flit on each output |
| out_defl | output | 4 | Flit on this output was deflected |
| silver_vld | output | 1 | A silver flit was chosen this cycle |
| silver_idx | output | 2 | Input index of the silver flit |

## Verification
The sweep covers every valid mask against every combination of requested ports. This exposes steering errors in each stage and shows where the random tie bits and the silver choice decide the outcome. Four golden layouts are laid over the sweep:
- no golden flit, which isolates the silver and ordinary levels;
- one golden flit, which shows golden dominance;
- two golden flits with differing sequence numbers;
- all inputs golden with colliding sequence numbers, which exercises the lower-side tie rule.

Masks with one valid input separate the lone-flit rule from real arbitration. The bench tracks the pseudo-random register from the reset seed, so silver indices and tie outcomes are predicted cycle by cycle.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NPORT  = 4;
  localparam int PORT_W = 2;
  localparam int SEQ_W  = 4;
  localparam int DATA_W = 8;
  localparam int LFSR_W = 16;

  typedef struct packed {
    logic              vld;
    logic [PORT_W-1:0] dest;
    logic              gold;
    logic [SEQ_W-1:0]  seq;
    logic              sil;
    logic [DATA_W-1:0] data;
  } flit_t;
endpackage

// File: rtl/defl_lfsr.sv
module defl_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    SEED = 16'hACE1,
  parameter logic [W-1:0]    TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/defl_silver_pick.sv
module defl_silver_pick import defl_pkg::*; (
  input  logic [NPORT-1:0]  vld,
  input  logic [PORT_W-1:0] start,
  output logic              found,
  output logic [PORT_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NPORT; k++) begin
      logic [PORT_W-1:0] cand;
      cand = start + PORT_W'(k);
      if (!found && vld[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/defl_swap2.sv
module defl_swap2 import defl_pkg::*; #(
  parameter int SEL_BIT = 1
) (
  input  flit_t a,
  input  flit_t b,
  input  logic  tie,
  output flit_t o0,
  output flit_t o1
);
  logic  a_wins;
  flit_t win, lose;

  always_comb begin
    if (!b.vld)                 a_wins = 1'b1;
    else if (!a.vld)            a_wins = 1'b0;
    else if (a.gold != b.gold)  a_wins = a.gold;
    else if (a.gold)            a_wins = (a.seq <= b.seq);
    else if (a.sil != b.sil)    a_wins = a.sil;
    else                        a_wins = !tie;
  end

  assign win  = a_wins ? a : b;
  assign lose = a_wins ? b : a;
  assign o0   = win.dest[SEL_BIT] ? lose : win;
  assign o1   = win.dest[SEL_BIT] ? win  : lose;
endmodule

// File: rtl/defl_perm_arbiter.sv
module defl_perm_arbiter import defl_pkg::*; #(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         in_vld,
  input  logic [NPORT*PORT_W-1:0]  in_dest,
  input  logic [NPORT-1:0]         in_gold,
  input  logic [NPORT*SEQ_W-1:0]   in_seq,
  input  logic [NPORT*DATA_W-1:0]  in_data,
  output logic [NPORT-1:0]         out_vld,
  output logic [NPORT*PORT_W-1:0]  out_dest,
  output logic [NPORT-1:0]         out_gold,
  output logic [NPORT*SEQ_W-1:0]   out_seq,
  output logic [NPORT*DATA_W-1:0]  out_data,
  output logic [NPORT-1:0]         out_defl,
  output logic                     silver_vld,
  output logic [PORT_W-1:0]        silver_idx
);
  localparam int HALF = NPORT / 2;

  logic [LFSR_W-1:0] rnd;
  flit_t fin  [NPORT];
  flit_t mid  [HALF][HALF];
  flit_t fout [NPORT];

  defl_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) i_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd)
  );

  defl_silver_pick i_pick (
    .vld(in_vld), .start(rnd[1:0]), .found(silver_vld), .idx(silver_idx)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    always_comb begin
      fin[i] = '0;
      if (in_vld[i]) begin
        fin[i].vld  = 1'b1;
        fin[i].dest = in_dest[i*PORT_W +: PORT_W];
        fin[i].gold = in_gold[i];
        fin[i].seq  = in_seq[i*SEQ_W +: SEQ_W];
        fin[i].sil  = silver_vld && (silver_idx == PORT_W'(i));
        fin[i].data = in_data[i*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_st1
    defl_swap2 #(.SEL_BIT(1)) i_blk (
      .a(fin[k]), .b(fin[k+HALF]), .tie(rnd[2+k]),
      .o0(mid[k][0]), .o1(mid[k][1])
    );
  end

  for (genvar j = 0; j < HALF; j++) begin : g_st2
    defl_swap2 #(.SEL_BIT(0)) i_blk (
      .a(mid[0][j]), .b(mid[1][j]), .tie(rnd[2+HALF+j]),
      .o0(fout[2*j]), .o1(fout[2*j+1])
    );
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_out
    assign out_vld[i]                    = fout[i].vld;
    assign out_dest[i*PORT_W +: PORT_W]  = fout[i].dest;
    assign out_gold[i]                   = fout[i].gold;
    assign out_seq[i*SEQ_W +: SEQ_W]     = fout[i].seq;
    assign out_data[i*DATA_W +: DATA_W]  = fout[i].data;
    assign out_defl[i] = fout[i].vld && (fout[i].dest != PORT_W'(i));
  end
endmodule

// File: rtl/defl_perm_arbiter_chk.sv
module defl_perm_arbiter_chk import defl_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORT-1:0]  in_vld,
  input logic [NPORT-1:0]  in_gold,
  input logic [NPORT-1:0]  out_vld,
  input logic [NPORT-1:0]  out_gold,
  input logic [NPORT-1:0]  out_defl,
  input logic              silver_vld,
  input logic [PORT_W-1:0] silver_idx
);
  a_r1_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_vld) == $countones(in_vld));

  a_r2_defl_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_defl & ~out_vld) == '0);

  a_r6_silver_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    silver_vld |-> in_vld[silver_idx]);

  a_r6_silver_present: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_vld) |-> silver_vld);

  a_r8_one_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_vld) |-> ((out_vld & ~out_defl) != '0));

  a_r8_gold_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_vld & in_gold)) |-> (|(out_vld & out_gold & ~out_defl)));
endmodule

bind defl_perm_arbiter defl_perm_arbiter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_gold(in_gold),
  .out_vld(out_vld), .out_gold(out_gold), .out_defl(out_defl),
  .silver_vld(silver_vld), .silver_idx(silver_idx)
);

// File: tb/test_defl_perm_arbiter.sv
module test_defl_perm_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_vld = '0, in_gold = '0;
  logic [7:0]  in_dest = '0;
  logic [15:0] in_seq = '0;
  logic [31:0] in_data = '0;
  logic [3:0]  out_vld, out_gold, out_defl;
  logic [7:0]  out_dest;
  logic [15:0] out_seq;
  logic [31:0] out_data;
  logic        silver_vld;
  logic [1:0]  silver_idx;

  int errors = 0, checks = 0;
  logic [15:0] mdl;

  always #10 clk = ~clk;

  defl_perm_arbiter i_defl_perm_arbiter (.*);

  typedef struct packed {
    logic v; logic [1:0] d; logic g; logic [3:0] s; logic sl; logic [7:0] dat;
  } bf_t;

  bf_t exp_o [4];
  logic exp_sv;
  logic [1:0] exp_si;

  function automatic logic first_wins(bf_t a, bf_t b, logic r);
    if (!b.v) return 1'b1;
    if (!a.v) return 1'b0;
    if (a.g && !b.g) return 1'b1;
    if (b.g && !a.g) return 1'b0;
    if (a.g) return a.s <= b.s;
    if (a.sl && !b.sl) return 1'b1;
    if (b.sl && !a.sl) return 1'b0;
    return !r;
  endfunction

  task automatic block(input bf_t a, input bf_t b, input logic r, input int bitn,
                       output bf_t lo, output bf_t hi);
    bf_t w, l;
    if (first_wins(a, b, r)) begin w = a; l = b; end
    else begin w = b; l = a; end
    if (w.d[bitn]) begin lo = l; hi = w; end
    else begin lo = w; hi = l; end
  endtask

  task automatic predict();
    bf_t f [4];
    bf_t m00, m01, m10, m11;
    exp_sv = |in_vld;
    exp_si = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      logic [1:0] c;
      c = mdl[1:0] + 2'(k);
      if (in_vld[c]) exp_si = c;
    end
    for (int i = 0; i < 4; i++) begin
      f[i] = '0;
      if (in_vld[i]) begin
        f[i].v = 1'b1; f[i].d = in_dest[2*i +: 2]; f[i].g = in_gold[i];
        f[i].s = in_seq[4*i +: 4]; f[i].sl = exp_sv && exp_si == 2'(i);
        f[i].dat = in_data[8*i +: 8];
      end
    end
    block(f[0], f[2], mdl[2], 1, m00, m01);
    block(f[1], f[3], mdl[3], 1, m10, m11);
    block(m00, m10, mdl[4], 0, exp_o[0], exp_o[1]);
    block(m01, m11, mdl[5], 0, exp_o[2], exp_o[3]);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (vld=%b dest=%h gold=%b)",
               req, act, expv, in_vld, in_dest, in_gold);
    end
  endtask

  task automatic compare(input string req);
    predict();
    for (int i = 0; i < 4; i++) begin
      logic ed;
      ed = exp_o[i].v && exp_o[i].d != 2'(i);
      chk(req, {16'(out_data[8*i +: 8]), 4'(out_seq[4*i +: 4]), 2'(out_dest[2*i +: 2]),
                1'(out_gold[i]), 1'(out_vld[i])},
          {16'(exp_o[i].dat), 4'(exp_o[i].s), 2'(exp_o[i].d), 1'(exp_o[i].g), 1'(exp_o[i].v)});
      chk("R2 deflected flag", 32'(out_defl[i]), 32'(ed));
    end
    chk("R6 silver choice", {silver_vld, silver_idx}, {exp_sv, exp_si});
    if (in_vld != 0)
      chk("R8 some flit lands", 32'((out_vld & ~out_defl) != 0), 32'd1);
    if ($countones(in_vld) == 1)
      chk("R9 lone flit lands", 32'(out_defl), 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mdl = 16'hACE1;
    in_vld = 4'hF; in_dest = 8'hE4; in_data = 32'h33221100;
    repeat (3) @(negedge clk);
    #2 chk("R7 reset seed start", {silver_vld, silver_idx}, {1'b1, 2'd1});
    chk("R2 reset valid pass", 32'(out_vld), 32'hF);
    rst_n = 1'b1;
    for (int m = 0; m < 16; m++)
      for (int d = 0; d < 256; d++)
        for (int g = 0; g < 4; g++) begin
          string req;
          in_vld = 4'(m); in_dest = 8'(d);
          for (int i = 0; i < 4; i++) in_data[8*i +: 8] = 8'(i * 64 + (d + g) % 64);
          case (g)
            0: begin in_gold = 4'h0; in_seq = 16'(d * 7); req = "R5/R4 ordinary+silver"; end
            1: begin in_gold = 4'(1 << (d % 4)); in_seq = 16'(d * 13); req = "R3 one golden"; end
            2: begin in_gold = 4'(1 << (d % 4)) | 4'(1 << ((d / 4) % 4));
                      in_seq = 16'(d * 4099 + m); req = "R3 two golden"; end
            default: begin in_gold = 4'hF;
                      for (int i = 0; i < 4; i++) in_seq[4*i +: 4] = 4'((d * (i + 3)) >> 2);
                      req = "R3 all golden seq ties"; end
          endcase
          if (m == 0) req = "R1 bubbles";
          #2 compare(req);
          @(posedge clk);
          #1 mdl = {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
          @(negedge clk);
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule